// File: doc/BRIEF.md
# Edge-Catching External Interrupt Controller

This block is the front end for two external interrupt lines. Each line is fed by two input pins, called A and B. Each pin passes through its own two-flop synchroniser. A glitch filter then accepts a new level only after it has been stable for a set number of clocks. Each pin then has an edge catcher that can be set to rising, falling, both edges, or off.

Each line has a small control register. It holds the two pin edge modes and a two-bit field that either disables the line or gives its priority. Any latched catcher on an enabled line raises that line's request at the programmed priority. Several edges caught before service merge into a single pending request. The request is removed only by an interrupt-acknowledge naming that line, which clears both of the line's catchers. Software has no clear path.

An arbiter reports the winning line and its priority to the CPU interrupt logic. The highest priority wins. On equal priority the higher-numbered line wins.

Top module: `ext_irq_front`

## Requirements
- R1: A configuration write (`cfg_we_i` high on a clock edge) loads the control register of line `cfg_line_i` from `cfg_wdata_i`. The field positions are: bits 1:0 give the priority, bits 3:2 give the pin A edge mode, and bits 5:4 give the pin B edge mode. Pin A of line l is `pins_i[2l]` and pin B is `pins_i[2l+1]`. All registers reset to zero.
- R2: The edge mode encoding is 2'b00 off, 2'b10 rising only, 2'b01 falling only and 2'b11 both edges. An edge of a kind the mode does not select latches nothing.
- R3: A pin level must be seen after synchronisation for 3 consecutive clocks before its edge counts. A pulse that lasts 2 clocks is ignored. With a pin change set up before clock edge 1, the request appears after edge 6 and not after edge 5.
- R4: Priority code 2'b00 disables the line's request, while its catchers keep their state. Codes 2'b01, 2'b10 and 2'b11 request at priority 1, 2 and 3. Enabling a line that has a latched catcher raises its request at once.
- R5: `req_o[l]` is high when either catcher of line l is latched and the line's priority is non-zero. `req_prio_o[2l+1:2l]` always shows the line's priority field.
- R6: Edges caught on one or both pins of a line before service give one pending request, and a single acknowledge removes it.
- R7: An acknowledge (`ack_i` high with `ack_line_i` = l) clears both catchers of line l and leaves the other line untouched. Rewriting the control register with unchanged modes clears nothing.
- R8: A qualified edge that would latch on the same clock edge as an acknowledge for its line stays latched.
- R9: Writing mode 2'b00 for a pin clears that pin's catcher one clock edge after the write.
- R10: `top_valid_o` is high when any line requests. `top_line_o` and `top_prio_o` give the requesting line of highest priority. On equal priority line 1 wins over line 0.
- R11: After reset all requests and `top_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pins_i | input | 4 | Asynchronous interrupt pins, two per line |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_line_i | input | 1 | Line whose control register is written |
| cfg_wdata_i | input | 6 | Control register write data |
| ack_i | input | 1 | Interrupt-acknowledge strobe |
| ack_line_i | input | 1 | Line being acknowledged |
| req_o | output | 2 | Per-line request |
| req_prio_o | output | 4 | Per-line priority field, two bits per line |
| top_valid_o | output | 1 | Some line is requesting |
| top_line_o | output | 1 | Winning line |
| top_prio_o | output | 2 | Priority of the winning line |

## Verification
Directed pulses of 2 and 3 clocks separate glitches from qualified edges. The exact latency is checked at edges 5 and 6. Falling and rising edges are applied under each mode to show that only the selected kinds latch. Acknowledges are placed both away from a new edge and on the very edge where it latches, to tell clearing apart from keeping. Equal and unequal priorities across the two lines check the arbitration order. Random pin toggling then mixes hold lengths from 1 to 6 clocks with random writes and acknowledges. This covers glitches, qualified edges, merged edges and mode changes in combinations that the directed cases do not reach.

// File: rtl/eic_pkg.sv
// Shared types and field positions for the external interrupt front end.
// Assumes one control register per line with priority and two edge modes.
package eic_pkg;

    // Edge selection: bit 1 picks rising edges, bit 0 picks falling edges.
    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_FALL = 2'b01,
        EDGE_RISE = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_mode_e;

    localparam int CFG_W        = 6;
    localparam int PRIO_W       = 2;
    localparam int PRIO_LSB     = 0;
    localparam int MODE_A_LSB   = 2;
    localparam int MODE_W       = 2;
    localparam int PINS_PER_LINE = 2;

endpackage

// File: rtl/eic_sync.sv
// Multi-flop synchroniser for one asynchronous pin.
// Assumes STAGES >= 2; output is the last stage.
module eic_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] st_q;

    // Shift the pin level through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= {st_q[STAGES-2:0], d_i};
    end

    assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/eic_qual.sv
// Glitch filter: accepts a new synchronised level only after it has been
// seen on QUAL_CYCLES consecutive clocks, and emits one-cycle rise/fall
// pulses when the accepted level changes. Assumes QUAL_CYCLES >= 3 for
// the embedded checks.
module eic_qual #(
    parameter int QUAL_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic s_i,
    output logic rise_o,
    output logic fall_o
);
    localparam int CW = $clog2(QUAL_CYCLES + 1);

    logic          level_q;
    logic [CW-1:0] cnt_q;
    logic          rise_q, fall_q;

    // Count clocks of disagreement and accept the new level at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= 1'b0;
            cnt_q   <= '0;
            rise_q  <= 1'b0;
            fall_q  <= 1'b0;
        end else begin
            rise_q <= 1'b0;
            fall_q <= 1'b0;
            if (s_i == level_q) begin
                cnt_q <= '0;
            end else if (cnt_q == CW'(QUAL_CYCLES - 1)) begin
                level_q <= s_i;
                cnt_q   <= '0;
                rise_q  <= s_i;
                fall_q  <= !s_i;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign rise_o = rise_q;
    assign fall_o = fall_q;

    // R3: an accepted rise needs the input high on the last three samples
    a_r3_rise_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(level_q) |-> ($past(s_i) && $past(s_i, 2) && $past(s_i, 3)));
    // R3: an accepted fall needs the input low on the last three samples
    a_r3_fall_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(level_q) |-> (!$past(s_i) && !$past(s_i, 2) && !$past(s_i, 3)));
endmodule

// File: rtl/eic_catch.sv
// Edge catcher for one pin: latches a qualified edge of the selected kind,
// is cleared by an acknowledge of its line (a same-cycle edge wins), and
// is cleared while its mode is off.
module eic_catch
    import eic_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  edge_mode_e mode_i,
    input  logic       rise_i,
    input  logic       fall_i,
    input  logic       ack_i,
    output logic       latched_o
);
    logic lat_q;
    logic hit;

    // Select the edge kinds the mode asks for.
    always_comb hit = (rise_i && mode_i[1]) || (fall_i && mode_i[0]);

    // Latch state: mode off clears, a hit sets, an acknowledge clears.
    always_ff @(posedge clk) begin
        if (!rst_n)                 lat_q <= 1'b0;
        else if (mode_i == EDGE_OFF) lat_q <= 1'b0;
        else if (hit)               lat_q <= 1'b1;
        else if (ack_i)             lat_q <= 1'b0;
    end

    assign latched_o = lat_q;

    // R7: the latch drops only through an acknowledge or a disabled mode
    a_r7_clear_source: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lat_q) |-> ($past(ack_i) || ($past(mode_i) == EDGE_OFF)));
    // R8: a selected edge is latched even with a simultaneous acknowledge
    a_r8_edge_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (((rise_i && mode_i[1]) || (fall_i && mode_i[0])) && ack_i) |=> lat_q);
    // R9: a disabled mode leaves the catcher empty on the next cycle
    a_r9_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == EDGE_OFF) |=> !lat_q);
endmodule

// File: rtl/eic_arb.sv
// Fixed-priority arbiter across lines: highest priority wins, ties go to
// the higher-numbered line. Assumes requests only carry non-zero priority.
module eic_arb #(
    parameter int NUM_LINES = 2,
    parameter int PRIO_W    = 2,
    parameter int LW        = 1
) (
    input  logic [NUM_LINES-1:0]        req_i,
    input  logic [NUM_LINES*PRIO_W-1:0] prio_i,
    output logic                        valid_o,
    output logic [LW-1:0]               line_o,
    output logic [PRIO_W-1:0]           prio_o
);
    // Scan upward; >= makes a later (higher) line win a tie.
    always_comb begin
        valid_o = 1'b0;
        line_o  = '0;
        prio_o  = '0;
        for (int l = 0; l < NUM_LINES; l++) begin
            if (req_i[l] && (prio_i[l*PRIO_W +: PRIO_W] >= prio_o)) begin
                valid_o = 1'b1;
                line_o  = LW'(l);
                prio_o  = prio_i[l*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/ext_irq_front.sv
// External interrupt front end: per-line control registers, per-pin
// synchroniser, qualifier and catcher, per-line request gating, and
// arbitration. Assumes NUM_LINES >= 2 and two pins per line.
module ext_irq_front
    import eic_pkg::*;
#(
    parameter int NUM_LINES   = 2,
    parameter int SYNC_STAGES = 2,
    parameter int QUAL_CYCLES = 3,
    parameter int LW          = $clog2(NUM_LINES),
    parameter int NP          = NUM_LINES * PINS_PER_LINE
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NP-1:0]               pins_i,
    input  logic                        cfg_we_i,
    input  logic [LW-1:0]               cfg_line_i,
    input  logic [CFG_W-1:0]            cfg_wdata_i,
    input  logic                        ack_i,
    input  logic [LW-1:0]               ack_line_i,
    output logic [NUM_LINES-1:0]        req_o,
    output logic [NUM_LINES*PRIO_W-1:0] req_prio_o,
    output logic                        top_valid_o,
    output logic [LW-1:0]               top_line_o,
    output logic [PRIO_W-1:0]           top_prio_o
);
    logic [PRIO_W-1:0] prio_q [NUM_LINES];
    edge_mode_e        mode_q [NP];
    logic [NP-1:0]     lat;

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        logic wr_hit;
        logic ack_hit;
        assign wr_hit  = cfg_we_i && (cfg_line_i == LW'(l));
        assign ack_hit = ack_i && (ack_line_i == LW'(l));

        // Priority field of this line's control register.
        always_ff @(posedge clk) begin
            if (!rst_n)      prio_q[l] <= '0;
            else if (wr_hit) prio_q[l] <= cfg_wdata_i[PRIO_LSB +: PRIO_W];
        end

        for (genvar p = 0; p < PINS_PER_LINE; p++) begin : g_pin
            localparam int PI  = l * PINS_PER_LINE + p;
            localparam int LSB = MODE_A_LSB + p * MODE_W;
            logic s, rise, fall;

            // Edge mode field for this pin.
            always_ff @(posedge clk) begin
                if (!rst_n)      mode_q[PI] <= EDGE_OFF;
                else if (wr_hit) mode_q[PI] <= edge_mode_e'(cfg_wdata_i[LSB +: MODE_W]);
            end

            eic_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk(clk), .rst_n(rst_n), .d_i(pins_i[PI]), .q_o(s));

            eic_qual #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
                .clk(clk), .rst_n(rst_n), .s_i(s), .rise_o(rise), .fall_o(fall));

            eic_catch u_catch (
                .clk(clk), .rst_n(rst_n), .mode_i(mode_q[PI]),
                .rise_i(rise), .fall_i(fall), .ack_i(ack_hit),
                .latched_o(lat[PI]));
        end

        // Line request: any latched catcher, gated by a non-zero priority.
        assign req_o[l] = (|lat[l*PINS_PER_LINE +: PINS_PER_LINE]) && (prio_q[l] != '0);
        assign req_prio_o[l*PRIO_W +: PRIO_W] = prio_q[l];

        // R4: a disabled line never requests
        a_r4_prio_gate: assert property (@(posedge clk) disable iff (!rst_n)
            (prio_q[l] == '0) |-> !req_o[l]);
        // R10: a requesting line never outranks the reported winner
        a_r10_not_above: assert property (@(posedge clk) disable iff (!rst_n)
            req_o[l] |-> (top_valid_o && (prio_q[l] <= top_prio_o)));
        // R10: a higher line with equal priority cannot lose
        a_r10_tie_high: assert property (@(posedge clk) disable iff (!rst_n)
            (req_o[l] && (LW'(l) > top_line_o)) |-> (prio_q[l] < top_prio_o));
    end

    eic_arb #(.NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W), .LW(LW)) u_arb (
        .req_i(req_o), .prio_i(req_prio_o),
        .valid_o(top_valid_o), .line_o(top_line_o), .prio_o(top_prio_o));

    // R10: the winner line is itself requesting at the reported priority
    a_r10_winner_real: assert property (@(posedge clk) disable iff (!rst_n)
        top_valid_o |-> (req_o[top_line_o] && (prio_q[top_line_o] == top_prio_o)));
    // R11: nothing requests in the cycle after a reset
    a_r11_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (req_o == '0));
endmodule

// File: tb/tb_ext_irq_front.sv
// Self-checking bench: directed corner cases plus seeded random stimulus,
// compared every check against a cycle model built from the requirements.
module tb_ext_irq_front;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] pins = '0;
    logic       cfg_we = 1'b0;
    logic [0:0] cfg_line = '0;
    logic [5:0] cfg_wdata = '0;
    logic       ack = 1'b0;
    logic [0:0] ack_line = '0;
    logic [1:0] req;
    logic [3:0] req_prio;
    logic       top_valid;
    logic [0:0] top_line;
    logic [1:0] top_prio;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_irq_front dut (
        .clk(clk), .rst_n(rst_n), .pins_i(pins),
        .cfg_we_i(cfg_we), .cfg_line_i(cfg_line), .cfg_wdata_i(cfg_wdata),
        .ack_i(ack), .ack_line_i(ack_line),
        .req_o(req), .req_prio_o(req_prio),
        .top_valid_o(top_valid), .top_line_o(top_line), .top_prio_o(top_prio));

    // ---------------- reference model (from the requirements) ----------
    logic [1:0] m_prio [2];
    logic [1:0] m_mode [4];
    logic [3:0] m_s1, m_s2, m_q, m_er, m_ef, m_lat;
    logic [2:0] m_w [4];

    task automatic model_step();
        logic [3:0] nl, ner, nef;
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin m_mode[i] = 2'b00; m_w[i] = 3'b000; end
            m_prio[0] = 2'b00; m_prio[1] = 2'b00;
            m_s1 = '0; m_s2 = '0; m_q = '0; m_er = '0; m_ef = '0; m_lat = '0;
            return;
        end
        for (int i = 0; i < 4; i++) begin
            logic hit;
            hit = (m_er[i] && m_mode[i][1]) || (m_ef[i] && m_mode[i][0]);
            if (m_mode[i] == 2'b00)                 nl[i] = 1'b0;
            else if (hit)                           nl[i] = 1'b1;
            else if (ack && (ack_line == 1'(i/2)))  nl[i] = 1'b0;
            else                                    nl[i] = m_lat[i];
            m_w[i] = {m_w[i][1:0], m_s2[i]};
            ner[i] = 1'b0; nef[i] = 1'b0;
            if (m_w[i] == {3{~m_q[i]}}) begin
                ner[i] = ~m_q[i];
                nef[i] = m_q[i];
                m_q[i] = ~m_q[i];
            end
        end
        m_lat = nl; m_er = ner; m_ef = nef;
        m_s2 = m_s1; m_s1 = pins;
        if (cfg_we) begin
            m_prio[cfg_line] = cfg_wdata[1:0];
            m_mode[2*cfg_line]   = cfg_wdata[3:2];
            m_mode[2*cfg_line+1] = cfg_wdata[5:4];
        end
    endtask

    always @(posedge clk) model_step();

    function automatic logic [1:0] exp_req();
        for (int l = 0; l < 2; l++)
            exp_req[l] = (m_lat[2*l] || m_lat[2*l+1]) && (m_prio[l] != 2'b00);
    endfunction

    function automatic logic [3:0] exp_top();  // {valid, line, prio}
        logic [1:0] r;
        r = exp_req();
        exp_top = 4'b0;
        if (r[1] && (!r[0] || m_prio[1] >= m_prio[0])) exp_top = {1'b1, 1'b1, m_prio[1]};
        else if (r[0])                                 exp_top = {1'b1, 1'b0, m_prio[0]};
    endfunction

    // ---------------- check helpers -------------------------------------
    task automatic check_val(string tag, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        logic [3:0] t;
        t = exp_top();
        check_val(tag, "req_o", int'(req), int'(exp_req()));
        check_val(tag, "req_prio_o", int'(req_prio), int'({m_prio[1], m_prio[0]}));
        check_val(tag, "top", int'({top_valid, top_line, top_prio}), int'(t));
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(int line, logic [5:0] d);
        cfg_we = 1'b1; cfg_line = 1'(line); cfg_wdata = d;
        tick(1);
        cfg_we = 1'b0;
    endtask

    task automatic do_ack(int line);
        ack = 1'b1; ack_line = 1'(line);
        tick(1);
        ack = 1'b0;
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    // ---------------- watchdog ------------------------------------------
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    // ---------------- stimulus ------------------------------------------
    initial begin
        int hold [4];
        void'($urandom(32'd20240611));
        tick(4);
        rst_n = 1'b1;
        tick(1);
        // R11: idle after reset
        check_val("R11", "req_o", int'(req), 0);
        check_val("R11", "top_valid_o", int'(top_valid), 0);

        // R1/R3: line 0, pin A rising, priority 2; latency of six edges
        wr(0, 6'b00_10_10);
        pins[0] = 1'b1;
        tick(5);
        check_val("R3", "req_o[0] after 5 edges", int'(req[0]), 0);
        tick(1);
        check_val("R3", "req_o[0] after 6 edges", int'(req[0]), 1);
        check_val("R5", "req_prio_o[1:0]", int'(req_prio[1:0]), 2);
        check_val("R10", "top_prio_o", int'(top_prio), 2);
        check_all("R1");

        // R7: acknowledge clears; R2: falling edge ignored under rising mode
        do_ack(0);
        check_val("R7", "req_o[0] after ack", int'(req[0]), 0);
        pins[0] = 1'b0;
        tick(8);
        check_val("R2", "req_o[0] falling under rise mode", int'(req[0]), 0);
        check_all("R2");

        // R3: 2-cycle glitch ignored, 3-cycle pulse caught (pin B both)
        wr(0, 6'b11_10_10);
        pins[1] = 1'b1; tick(2); pins[1] = 1'b0;
        tick(8);
        check_val("R3", "req_o[0] after 2-cycle glitch", int'(req[0]), 0);
        pins[1] = 1'b1; tick(3); pins[1] = 1'b0;
        tick(8);
        check_val("R3", "req_o[0] after 3-cycle pulse", int'(req[0]), 1);
        check_all("R3");
        do_ack(0);

        // R6: edges on both pins merge into one request, one ack removes it
        pins[0] = 1'b1; pins[1] = 1'b1;
        tick(8);
        check_val("R6", "req_o[0] merged", int'(req[0]), 1);
        do_ack(0);
        tick(6);
        check_val("R6", "req_o[0] after single ack", int'(req[0]), 0);
        check_all("R6");

        // R4: priority 0 blocks the request but keeps the catcher
        wr(1, 6'b00_10_00);
        pins[2] = 1'b1;
        tick(8);
        check_val("R4", "req_o[1] disabled", int'(req[1]), 0);
        wr(1, 6'b00_10_11);
        check_val("R4", "req_o[1] after enable", int'(req[1]), 1);
        check_all("R4");

        // R10: higher priority wins, tie goes to line 1
        pins[1] = 1'b0;
        tick(8);
        check_val("R10", "top_line_o prio3 vs prio2", int'(top_line), 1);
        wr(0, 6'b11_10_11);
        check_val("R10", "top_line_o tie", int'(top_line), 1);
        check_val("R10", "top_prio_o tie", int'(top_prio), 3);
        wr(1, 6'b00_10_01);
        check_val("R10", "top_line_o line0 higher", int'(top_line), 0);
        check_all("R10");

        // R7: ack of line 1 leaves line 0; rewriting modes clears nothing
        do_ack(1);
        check_val("R7", "req_o after ack line1", int'(req), 1);
        wr(0, 6'b11_10_11);
        tick(2);
        check_val("R7", "req_o[0] after rewrite", int'(req[0]), 1);
        check_all("R7");

        // R8: an edge latching on the acknowledge edge is kept
        pins[0] = 1'b0; tick(8); do_ack(0);
        pins[0] = 1'b1;
        tick(5);
        ack = 1'b1; ack_line = 1'b0;
        tick(1);
        ack = 1'b0;
        check_val("R8", "req_o[0] edge on ack cycle", int'(req[0]), 1);
        check_all("R8");
        do_ack(0);
        check_val("R8", "req_o[0] after second ack", int'(req[0]), 0);

        // R9: turning pin B off clears its catcher
        pins[1] = 1'b1;
        tick(8);
        check_val("R9", "req_o[0] before off", int'(req[0]), 1);
        wr(0, 6'b00_10_11);
        tick(1);
        check_val("R9", "req_o[0] after mode off", int'(req[0]), 0);
        check_all("R9");

        // Random phase: mixed hold lengths, writes and acknowledges
        for (int i = 0; i < 4; i++) hold[i] = 1;
        for (int c = 0; c < 4000; c++) begin
            check_all("R5");
            for (int i = 0; i < 4; i++) begin
                hold[i]--;
                if (hold[i] <= 0) begin
                    pins[i] = ~pins[i];
                    hold[i] = int'($urandom_range(1, 6));
                end
            end
            cfg_we = ($urandom_range(0, 39) == 0);
            cfg_line = 1'($urandom_range(0, 1));
            cfg_wdata = 6'($urandom);
            ack = ($urandom_range(0, 7) == 0);
            ack_line = 1'($urandom_range(0, 1));
            tick(1);
        end
        cfg_we = 1'b0; ack = 1'b0;
        tick(1);
        check_all("R10");
        summary();
    end
endmodule